// File: doc/BRIEF.md
# Wrapping Burst Column Address Sequencer

This block sits on the controller side of a double-data-rate memory interface and produces, one per clock, the column address of every data word of a burst. A mode-load strobe programs the burst length from a small address field; a command strobe then supplies a starting column and a read/write flag. From the cycle after the command is taken, the block presents one column per cycle until the burst is complete.

The low bits of the column advance modulo the burst length. The sequence therefore wraps inside an aligned block of 2, 4 or 8 words, and the bits above that block stay fixed. A last flag marks the final word. While a burst runs, busy is high and further commands are dropped. Mode loads that encode an unsupported length are ignored.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, out_valid, out_last and busy are low, and the burst length is 2 until a legal mode load is taken.
- R2: A mode load with mode_addr[3]=0 and mode_addr[2:0] equal to 3'b001, 3'b010 or 3'b011 sets the burst length to 2, 4 or 8 words.
- R3: A mode load with any other value on mode_addr is ignored, and the previous burst length is kept.
- R4: A command is taken on a clock edge only if cmd_valid is high and busy is low. In the next cycle out_valid and busy are high and out_col equals the start column.
- R5: A burst of length BL drives out_valid high for exactly BL consecutive cycles.
- R6: Within a burst, the low log2(BL) bits of out_col step by +1 modulo BL each cycle. For example, a start of 2 with BL=4 gives 2,3,0,1, and a start of 5 with BL=8 gives 5,6,7,0,1,2,3,4.
- R7: The bits of out_col above the low log2(BL) bits equal those of the start column for the whole burst.
- R8: out_last is high only with the final word of a burst, and busy is low in the following cycle.
- R9: A command presented while busy is high is dropped. It changes neither the running sequence nor anything afterwards.
- R10: A mode load takes effect for the next command only. A burst in progress keeps its length, and a command taken on the same edge as a mode load uses the previous length.
- R11: out_wr equals the cmd_wr value of the taken command for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ld | input | 1 | Mode-load strobe |
| mode_addr | input | MODE_W (4) | Mode field: [2:0] length code, [3] must be 0 |
| cmd_valid | input | 1 | Command strobe |
| cmd_wr | input | 1 | 1 = write burst, 0 = read burst |
| cmd_col | input | COL_W (8) | Starting column |
| out_col | output | COL_W (8) | Column of the current data word |
| out_valid | output | 1 | A column is presented this cycle |
| out_last | output | 1 | Final word of the burst |
| out_wr | output | 1 | Direction of the current burst |
| busy | output | 1 | Burst in progress; commands are dropped |

## Verification
A corrupted length register shows up as a burst of the wrong word count and a misplaced out_last. This is visible within at most eight cycles of the next command. A faulty word index or mask appears at once, as an out_col that breaks the wrap order or changes bits above the wrap field, on the first word that steps past the fault. A busy flag stuck high or low shows either as a dropped legal command or as a second burst accepted over a running one. Both are seen within one burst.

// File: rtl/burst_seq_pkg.sv
// Package: shared widths and the mode field length codes.
// Assumes a 4-bit mode field, of which only bits [3:0] are decoded.
package burst_seq_pkg;
    localparam int LOG_W = 2;                 // holds log2(BL) = 1..3
    localparam logic [2:0] CODE_BL2 = 3'b001;
    localparam logic [2:0] CODE_BL4 = 3'b010;
    localparam logic [2:0] CODE_BL8 = 3'b011;
    typedef logic [LOG_W-1:0] bl_log_t;
endpackage

// File: rtl/burst_len_reg.sv
// Burst length register: decodes a mode load into log2(BL).
// Assumes illegal codes must leave the stored length untouched.
module burst_len_reg
    import burst_seq_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld,
    input  logic [MODE_W-1:0] mode_addr,
    output bl_log_t           bl_log
);
    logic    legal;
    bl_log_t decoded;

    // Map the length code to log2(BL); flag anything unsupported.
    always_comb begin
        legal   = !mode_addr[3];
        decoded = 2'd1;
        unique case (mode_addr[2:0])
            CODE_BL2: decoded = 2'd1;
            CODE_BL4: decoded = 2'd2;
            CODE_BL8: decoded = 2'd3;
            default:  legal   = 1'b0;
        endcase
    end

    // Store the length on a legal load; reset to length 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bl_log <= 2'd1;
        else if (mode_ld && legal)
            bl_log <= decoded;
    end

    // R2: stored length is always one of the supported values
    a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bl_log != 2'd0);
    // R3: an illegal load never changes the stored length
    a_r3_illegal_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ld && !legal) |=> $stable(bl_log));
endmodule

// File: rtl/burst_ctrl.sv
// Burst control: takes commands when idle, latches start, mask and
// direction, and counts words up to the burst length.
// Assumes bl_log is already a legal value (1..3).
module burst_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  bl_log_t          bl_log,
    output logic             active,
    output logic             last,
    output logic             wr_q,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] idx_q,
    output logic [COL_W-1:0] mask_q
);
    logic             take;
    logic [COL_W-1:0] new_mask;

    // Accept a command only while idle; mask = BL - 1.
    always_comb begin
        take     = cmd_valid && !active;
        new_mask = (COL_W'(1) << bl_log) - COL_W'(1);
        last     = active && (idx_q == mask_q);
    end

    // Run state and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx_q  <= '0;
        end else if (take) begin
            active <= 1'b1;
            idx_q  <= '0;
        end else if (active) begin
            active <= !last;
            idx_q  <= idx_q + COL_W'(1);
        end
    end

    // Latch the command fields when a command is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= COL_W'(1);
            wr_q   <= 1'b0;
        end else if (take) begin
            base_q <= cmd_col;
            mask_q <= new_mask;
            wr_q   <= cmd_wr;
        end
    end

    // R8: busy clears in the cycle after the last word
    a_r8_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !active);
    // R9: a command during a burst leaves the latched fields alone
    a_r9_drop_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd_valid) |=> ($stable(base_q) && $stable(wr_q) && $stable(mask_q)));
    // R5: the index never runs past the burst length
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((idx_q & ~mask_q) == '0));
endmodule

// File: rtl/burst_wrap_addr.sv
// Wrap address unit: forms the column from the start, the word index
// and the wrap mask. Combinational.
// Assumes mask is 2^n - 1.
module burst_wrap_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] col
);
    // High bits from the start, low bits advance modulo BL.
    always_comb begin
        col = (base & ~mask) | ((base + idx) & mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
// Top: wrapping burst column address sequencer. One column per clock
// for each data word, wrapping inside the aligned burst block.
// Assumes a mode load and a command on the same edge: command uses old length.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld,
    input  logic [MODE_W-1:0] mode_addr,
    input  logic              cmd_valid,
    input  logic              cmd_wr,
    input  logic [COL_W-1:0]  cmd_col,
    output logic [COL_W-1:0]  out_col,
    output logic              out_valid,
    output logic              out_last,
    output logic              out_wr,
    output logic              busy
);
    bl_log_t          bl_log;
    logic             active;
    logic             last;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;

    burst_len_reg #(.MODE_W(MODE_W)) u_len (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld),
        .mode_addr(mode_addr), .bl_log(bl_log)
    );

    burst_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
        .cmd_col(cmd_col), .bl_log(bl_log), .active(active), .last(last),
        .wr_q(out_wr), .base_q(base_q), .idx_q(idx_q), .mask_q(mask_q)
    );

    burst_wrap_addr #(.COL_W(COL_W)) u_wrap (
        .base(base_q), .idx(idx_q), .mask(mask_q), .col(out_col)
    );

    // Drive the handshake outputs from the run state.
    always_comb begin
        out_valid = active;
        busy      = active;
        out_last  = last;
    end

    // R6: low bits step +1 modulo BL between consecutive words
    a_r6_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> ((out_col & mask_q) == (($past(out_col) + COL_W'(1)) & mask_q)));
    // R7: bits above the wrap field hold for the whole burst
    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> ((out_col & ~mask_q) == ($past(out_col) & ~mask_q)));
    // R4: the first word presents the start column
    a_r4_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (out_valid && out_col == $past(cmd_col)));
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ld = 1'b0;
    logic [3:0] mode_addr = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_col = '0;
    logic [7:0] out_col;
    logic       out_valid, out_last, out_wr, busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_addr(mode_addr),
        .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_col(cmd_col),
        .out_col(out_col), .out_valid(out_valid), .out_last(out_last),
        .out_wr(out_wr), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_mode(input logic [3:0] code);
        mode_ld = 1'b1; mode_addr = code;
        @(negedge clk);
        mode_ld = 1'b0; mode_addr = '0;
    endtask

    // Issue a command at a negedge, then check every word of the burst.
    task automatic run_burst(input string req, input int bl, input logic [7:0] start,
                             input logic wr);
        cmd_valid = 1'b1; cmd_wr = wr; cmd_col = start;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < bl; k++) begin
            int exp_col;
            exp_col = (int'(start) & ~(bl-1) & 8'hFF) | ((int'(start) + k) & (bl-1));
            chk({req, " valid"}, int'(out_valid), 1);
            chk({req, " busy"}, int'(busy), 1);
            chk({req, " col"}, int'(out_col), exp_col);
            chk({req, " last"}, int'(out_last), (k == bl-1) ? 1 : 0);
            chk({req, " wr"}, int'(out_wr), int'(wr));
            @(negedge clk);
        end
        chk({req, " R8 busy after last"}, int'(busy), 0);
        chk({req, " R5 valid after burst"}, int'(out_valid), 0);
    endtask

    task automatic t_reset();
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 last", int'(out_last), 0);
        chk("R1 busy", int'(busy), 0);
        run_burst("R1 default BL2", 2, 8'h37, 1'b0);
    endtask

    task automatic t_lengths();
        load_mode(4'b0010);
        run_burst("R2 R6 BL4 start2", 4, 8'h02, 1'b1);
        load_mode(4'b0011);
        run_burst("R2 R6 BL8 start5", 8, 8'h05, 1'b0);
        run_burst("R7 BL8 upper", 8, 8'hAE, 1'b1);
        load_mode(4'b0001);
        run_burst("R2 BL2 odd", 2, 8'hC1, 1'b0);
    endtask

    task automatic t_illegal();
        load_mode(4'b0011);
        load_mode(4'b0000);
        run_burst("R3 code0 ignored", 8, 8'h13, 1'b0);
        load_mode(4'b1010);
        run_burst("R3 bit3 ignored", 8, 8'h66, 1'b1);
        load_mode(4'b0111);
        run_burst("R3 code7 ignored", 8, 8'h09, 1'b0);
    endtask

    // R9: command while busy is dropped; R11: direction kept.
    task automatic t_drop();
        load_mode(4'b0010);
        cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_col = 8'h4B;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_col = 8'h90;
        for (int k = 0; k < 4; k++) begin
            chk("R9 col", int'(out_col), 8'h48 | ((8'h4B + k) & 3));
            chk("R11 wr kept", int'(out_wr), 1);
            chk("R9 last", int'(out_last), (k == 3) ? 1 : 0);
            @(negedge clk);
            if (k == 2) cmd_valid = 1'b0;
        end
        chk("R9 no second burst busy", int'(busy), 0);
        @(negedge clk);
        chk("R9 no second burst valid", int'(out_valid), 0);
    endtask

    // R10: mode load during a burst and together with a command.
    task automatic t_mode_timing();
        load_mode(4'b0010);
        cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_col = 8'h20;
        @(negedge clk);
        cmd_valid = 1'b0;
        mode_ld = 1'b1; mode_addr = 4'b0011;
        for (int k = 0; k < 4; k++) begin
            chk("R10 running keeps length last", int'(out_last), (k == 3) ? 1 : 0);
            @(negedge clk);
            mode_ld = 1'b0;
        end
        chk("R10 end busy", int'(busy), 0);
        run_burst("R10 next uses BL8", 8, 8'h23, 1'b1);
        mode_ld = 1'b1; mode_addr = 4'b0001;
        run_burst("R10 same edge old BL8", 8, 8'h71, 1'b0);
        run_burst("R10 then BL2", 2, 8'h71, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_illegal();
        t_drop();
        t_mode_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule